// File: doc/BRIEF.md
# CSR Access Permission Checker

This block decides, in the same cycle, whether an instruction that reads or writes a control and status register may go ahead. The decode stage gives it the 12-bit register address, whether the instruction intends to write, and a snapshot of the hart's state: privilege level, virtualization, debugger access, the 32/64-bit register width, the implemented privileged-architecture version, the feature enables, and the enable bits that gate the supervisor timer-compare and state-enable registers. It returns one of three verdicts: allowed, illegal instruction, or virtual-instruction fault. The trap logic turns that verdict into an exception.

The checks run in a fixed order and the first one that fails sets the verdict. First, CSR instructions must be supported. Second, the register's minimum architecture version must not be above the implemented one. Third, a write must not target a read-only register. Last comes the check that belongs to the register itself. Because of this order, a write to a read-only register reports illegal instruction before any per-register check could raise a virtual-instruction fault. The check of the address privilege field against the current level happens elsewhere. Register storage and trap entry are also outside this block.

Top module: `csr_perm_check`

## Requirements
- R1: An address whose bits [11:10] are 2'b11 is read-only. With wr_intent high it yields illegal (2'b01), whatever the later checks would say. A read of it may be allowed.
- R2: With en_csr_insn low, every access yields illegal.
- R3: Timer-compare and state-enable registers need version code 2 or higher on impl_ver, else illegal. Plain registers need version 0.
- R4: Any address outside the decoded set yields illegal.
- R5: Timer-compare registers (0x14D, 0x15D, 0x24D, 0x25D) are illegal when en_sstc or time_present is low. The virtual-supervisor pair (0x24D, 0x25D) needs en_hmode. The supervisor pair (0x14D, 0x15D) needs en_smode.
- R6: For timer-compare registers, once the mode check passes, dbg_access high gives allowed. Machine mode (priv_mode 2'b11) is allowed too.
- R7: Below machine mode, timer-compare access needs both mcnt_tm and menv_stce, else illegal.
- R8: When virt_mode is high below machine mode, timer-compare access also needs hcnt_tm and henv_stce. If either is clear the verdict is virtual-instruction fault (2'b10), but R7 wins when it also fails.
- R9: High-half registers (timer-compare 0x15D/0x25D, state-enable 0x31C-0x31F and 0x61C-0x61F) are legal only with xlen32 high.
- R10: State-enable registers need en_stateen. The supervisor set (0x10C-0x10F) needs en_smode and the hypervisor set (0x60C-0x60F, 0x61C-0x61F) needs en_hmode. After that, dbg_access gives allowed. Below machine mode, mstateen_top[index] must be set, where index is address bits [1:0]; otherwise illegal. The machine set (0x30C-0x30F, 0x31C-0x31F) needs only en_stateen.
- R11: Protection registers (config 0x3A0-0x3AF, address 0x3B0-0x3BF) need en_pmp. With xlen32 low, config indexes 1 and 3 are illegal, while odd indexes of 4 and above are allowed.
- R12: The verdict is encoded as 2'b00 allowed, 2'b01 illegal, 2'b10 virtual-instruction fault; 2'b11 never appears. Plain registers are allowed once the ordered checks pass: 0x300, 0x340 and 0xF11-0xF14 always, 0x140 when en_smode is set, 0x600 when en_hmode is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| csr_addr | input | 12 | Register address of the instruction |
| wr_intent | input | 1 | Instruction will write the register |
| priv_mode | input | 2 | Current level: 00 user, 01 supervisor, 11 machine |
| virt_mode | input | 1 | Hart runs virtualized |
| dbg_access | input | 1 | Access comes from the debugger |
| xlen32 | input | 1 | Hart runs with 32-bit registers |
| impl_ver | input | 2 | Implemented privileged-architecture version code |
| en_csr_insn | input | 1 | CSR instructions supported |
| en_smode | input | 1 | Supervisor mode present |
| en_hmode | input | 1 | Hypervisor extension present |
| en_sstc | input | 1 | Supervisor timer-compare feature present |
| time_present | input | 1 | A time source is attached |
| en_stateen | input | 1 | State-enable feature present |
| en_pmp | input | 1 | Physical memory protection present |
| mcnt_tm | input | 1 | Machine counter-enable time bit |
| menv_stce | input | 1 | Machine envcfg timer-compare enable bit |
| hcnt_tm | input | 1 | Hypervisor counter-enable time bit |
| henv_stce | input | 1 | Hypervisor envcfg timer-compare enable bit |
| mstateen_top | input | 4 | Top bit of each machine state-enable register |
| verdict | output | 2 | Access result |

## Verification
The hardest case to reach is the virtual-instruction fault. It needs a timer-compare address together with every earlier gate passing: feature, time source, mode, version, not the debugger, below machine mode, both machine enable bits set, virtualization on, and at least one hypervisor enable bit clear. Random vectors rarely hit that combination. Directed steps start from an all-permissive baseline and clear one enable at a time, then clear two at once to confirm that illegal wins over the fault. Random traffic drawn from a short list of decoded and undecoded addresses then covers the mixtures.

// File: rtl/csr_perm_pkg.sv
package csr_perm_pkg;

    localparam int ADDR_W     = 12;
    localparam int VER_W      = 2;
    localparam int STATEEN_N  = 4;
    localparam int IDX_W      = 4;
    localparam int PMP_ODD_LIM = 4;

    localparam logic [VER_W-1:0] VER_BASE = 2'd0;
    localparam logic [VER_W-1:0] VER_NEW  = 2'd2;

    typedef enum logic [1:0] {
        RES_OK      = 2'b00,
        RES_ILLEGAL = 2'b01,
        RES_VIRT    = 2'b10
    } perm_res_e;

    typedef enum logic [1:0] {
        LVL_U = 2'b00,
        LVL_S = 2'b01,
        LVL_M = 2'b11
    } priv_lvl_e;

    typedef enum logic [3:0] {
        K_NONE,
        K_ANY,
        K_SMODE,
        K_HMODE,
        K_TCMP,
        K_SEN_S,
        K_SEN_H,
        K_SEN_M,
        K_PMPCFG,
        K_PMPADDR
    } csr_kind_e;

    typedef struct packed {
        csr_kind_e         kind;
        logic              hi_half;
        logic              via_hyp;
        logic [IDX_W-1:0]  idx;
        logic [VER_W-1:0]  min_ver;
    } csr_class_t;

    typedef struct packed {
        logic smode;
        logic hmode;
        logic sstc;
        logic timesrc;
        logic stateen;
        logic pmp;
    } feat_t;

    function automatic logic in_range(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] lo,
                                      input logic [ADDR_W-1:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

    function automatic logic is_read_only(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: 2] == 2'b11;
    endfunction

endpackage

// File: rtl/csr_perm_classify.sv
module csr_perm_classify
    import csr_perm_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output csr_class_t        cls
);
    always_comb begin
        cls         = '0;
        cls.kind    = K_NONE;
        cls.idx     = addr[IDX_W-1:0];
        cls.min_ver = VER_BASE;
        if (addr == 12'h300 || addr == 12'h340 || in_range(addr, 12'hF11, 12'hF14)) begin
            cls.kind = K_ANY;
        end else if (addr == 12'h140) begin
            cls.kind = K_SMODE;
        end else if (addr == 12'h600) begin
            cls.kind = K_HMODE;
        end else if (addr == 12'h14D || addr == 12'h15D ||
                     addr == 12'h24D || addr == 12'h25D) begin
            cls.kind    = K_TCMP;
            cls.hi_half = addr[4];
            cls.via_hyp = addr[9];
            cls.min_ver = VER_NEW;
        end else if (in_range(addr, 12'h10C, 12'h10F)) begin
            cls.kind    = K_SEN_S;
            cls.min_ver = VER_NEW;
        end else if (in_range(addr, 12'h60C, 12'h60F) || in_range(addr, 12'h61C, 12'h61F)) begin
            cls.kind    = K_SEN_H;
            cls.hi_half = addr[4];
            cls.min_ver = VER_NEW;
        end else if (in_range(addr, 12'h30C, 12'h30F) || in_range(addr, 12'h31C, 12'h31F)) begin
            cls.kind    = K_SEN_M;
            cls.hi_half = addr[4];
            cls.min_ver = VER_NEW;
        end else if (in_range(addr, 12'h3A0, 12'h3AF)) begin
            cls.kind = K_PMPCFG;
        end else if (in_range(addr, 12'h3B0, 12'h3BF)) begin
            cls.kind = K_PMPADDR;
        end
    end
endmodule

// File: rtl/csr_perm_tcmp_gate.sv
module csr_perm_tcmp_gate
    import csr_perm_pkg::*;
(
    input  csr_class_t cls,
    input  feat_t      feat,
    input  priv_lvl_e  lvl,
    input  logic       virt,
    input  logic       dbg,
    input  logic       rv32,
    input  logic       m_tm,
    input  logic       m_stce,
    input  logic       h_tm,
    input  logic       h_stce,
    output perm_res_e  res
);
    logic mode_ok;
    assign mode_ok = cls.via_hyp ? feat.hmode : feat.smode;

    always_comb begin
        if (!feat.sstc || !feat.timesrc)      res = RES_ILLEGAL;
        else if (cls.hi_half && !rv32)        res = RES_ILLEGAL;
        else if (!mode_ok)                    res = RES_ILLEGAL;
        else if (dbg)                         res = RES_OK;
        else if (lvl == LVL_M)                res = RES_OK;
        else if (!(m_tm && m_stce))           res = RES_ILLEGAL;
        else if (virt && !(h_tm && h_stce))   res = RES_VIRT;
        else                                  res = RES_OK;
    end
endmodule

// File: rtl/csr_perm_stateen_gate.sv
module csr_perm_stateen_gate
    import csr_perm_pkg::*;
(
    input  csr_class_t           cls,
    input  feat_t                feat,
    input  priv_lvl_e            lvl,
    input  logic                 dbg,
    input  logic                 rv32,
    input  logic [STATEEN_N-1:0] m_top,
    output perm_res_e            res
);
    localparam int SEL_W = $clog2(STATEEN_N);

    logic mode_ok;
    logic top_set;

    assign mode_ok = (cls.kind == K_SEN_H) ? feat.hmode :
                     (cls.kind == K_SEN_S) ? feat.smode : 1'b1;
    assign top_set = m_top[cls.idx[SEL_W-1:0]];

    always_comb begin
        if (!feat.stateen)                           res = RES_ILLEGAL;
        else if (cls.hi_half && !rv32)               res = RES_ILLEGAL;
        else if (cls.kind == K_SEN_M)                res = RES_OK;
        else if (!mode_ok)                           res = RES_ILLEGAL;
        else if (dbg)                                res = RES_OK;
        else if (lvl != LVL_M && !top_set)           res = RES_ILLEGAL;
        else                                         res = RES_OK;
    end
endmodule

// File: rtl/csr_perm_check.sv
module csr_perm_check
    import csr_perm_pkg::*;
(
    input  logic [11:0] csr_addr,
    input  logic        wr_intent,
    input  logic [1:0]  priv_mode,
    input  logic        virt_mode,
    input  logic        dbg_access,
    input  logic        xlen32,
    input  logic [1:0]  impl_ver,
    input  logic        en_csr_insn,
    input  logic        en_smode,
    input  logic        en_hmode,
    input  logic        en_sstc,
    input  logic        time_present,
    input  logic        en_stateen,
    input  logic        en_pmp,
    input  logic        mcnt_tm,
    input  logic        menv_stce,
    input  logic        hcnt_tm,
    input  logic        henv_stce,
    input  logic [3:0]  mstateen_top,
    output logic [1:0]  verdict
);
    csr_class_t cls;
    feat_t      feat;
    priv_lvl_e  lvl;
    perm_res_e  tcmp_res;
    perm_res_e  sen_res;
    perm_res_e  pred_res;
    perm_res_e  final_res;

    assign feat = '{smode: en_smode, hmode: en_hmode, sstc: en_sstc,
                    timesrc: time_present, stateen: en_stateen, pmp: en_pmp};
    assign lvl  = priv_lvl_e'(priv_mode);

    csr_perm_classify u_classify (
        .addr (csr_addr),
        .cls  (cls)
    );

    csr_perm_tcmp_gate u_tcmp (
        .cls    (cls),
        .feat   (feat),
        .lvl    (lvl),
        .virt   (virt_mode),
        .dbg    (dbg_access),
        .rv32   (xlen32),
        .m_tm   (mcnt_tm),
        .m_stce (menv_stce),
        .h_tm   (hcnt_tm),
        .h_stce (henv_stce),
        .res    (tcmp_res)
    );

    csr_perm_stateen_gate u_stateen (
        .cls   (cls),
        .feat  (feat),
        .lvl   (lvl),
        .dbg   (dbg_access),
        .rv32  (xlen32),
        .m_top (mstateen_top),
        .res   (sen_res)
    );

    always_comb begin
        unique case (cls.kind)
            K_ANY:     pred_res = RES_OK;
            K_SMODE:   pred_res = feat.smode ? RES_OK : RES_ILLEGAL;
            K_HMODE:   pred_res = feat.hmode ? RES_OK : RES_ILLEGAL;
            K_TCMP:    pred_res = tcmp_res;
            K_SEN_S,
            K_SEN_H,
            K_SEN_M:   pred_res = sen_res;
            K_PMPCFG: begin
                if (!feat.pmp)
                    pred_res = RES_ILLEGAL;
                else if (!xlen32 && cls.idx[0] && (int'(cls.idx) < PMP_ODD_LIM))
                    pred_res = RES_ILLEGAL;
                else
                    pred_res = RES_OK;
            end
            K_PMPADDR: pred_res = feat.pmp ? RES_OK : RES_ILLEGAL;
            default:   pred_res = RES_ILLEGAL;
        endcase
    end

    always_comb begin
        if (!en_csr_insn)                            final_res = RES_ILLEGAL;
        else if (impl_ver < cls.min_ver)             final_res = RES_ILLEGAL;
        else if (wr_intent && is_read_only(csr_addr)) final_res = RES_ILLEGAL;
        else                                         final_res = pred_res;
    end

    assign verdict = final_res;
endmodule

// File: rtl/csr_perm_check_sva.sv
module csr_perm_check_sva (
    input logic [11:0] csr_addr,
    input logic        wr_intent,
    input logic [1:0]  priv_mode,
    input logic        virt_mode,
    input logic        dbg_access,
    input logic        en_csr_insn,
    input logic        en_pmp,
    input logic [1:0]  verdict
);
    always_comb begin
        if (!$isunknown({csr_addr, wr_intent, verdict})) begin
            if (wr_intent && csr_addr[11:10] == 2'b11)
                p_ro_write_illegal_r1: assert (verdict == 2'b01);
        end
        if (!$isunknown({en_csr_insn, verdict})) begin
            if (!en_csr_insn)
                p_insn_gate_r2: assert (verdict == 2'b01);
        end
        if (!$isunknown(verdict))
            p_no_code3_r12: assert (verdict != 2'b11);
        if (!$isunknown({verdict, virt_mode, dbg_access, priv_mode})) begin
            if (verdict == 2'b10)
                p_virt_fault_context_r8: assert (virt_mode && !dbg_access && priv_mode != 2'b11);
        end
        if (!$isunknown({csr_addr, en_pmp, verdict})) begin
            if (!en_pmp && csr_addr >= 12'h3A0 && csr_addr <= 12'h3BF)
                p_pmp_off_r11: assert (verdict == 2'b01);
        end
    end
endmodule

bind csr_perm_check csr_perm_check_sva u_sva (
    .csr_addr    (csr_addr),
    .wr_intent   (wr_intent),
    .priv_mode   (priv_mode),
    .virt_mode   (virt_mode),
    .dbg_access  (dbg_access),
    .en_csr_insn (en_csr_insn),
    .en_pmp      (en_pmp),
    .verdict     (verdict)
);

// File: tb/csr_perm_check_tb.sv
module csr_perm_check_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [11:0] csr_addr;
    logic wr_intent, virt_mode, dbg_access, xlen32;
    logic [1:0] priv_mode, impl_ver;
    logic en_csr_insn, en_smode, en_hmode, en_sstc, time_present, en_stateen, en_pmp;
    logic mcnt_tm, menv_stce, hcnt_tm, henv_stce;
    logic [3:0] mstateen_top;
    logic [1:0] verdict;

    int n_run = 0;
    int n_fail = 0;

    csr_perm_check u_dut (.*);

    task automatic baseline();
        csr_addr = 12'h300; wr_intent = 0; priv_mode = 2'b11; virt_mode = 0;
        dbg_access = 0; xlen32 = 0; impl_ver = 2'd2; en_csr_insn = 1;
        en_smode = 1; en_hmode = 1; en_sstc = 1; time_present = 1;
        en_stateen = 1; en_pmp = 1; mcnt_tm = 1; menv_stce = 1;
        hcnt_tm = 1; henv_stce = 1; mstateen_top = 4'hF;
    endtask

    // Behavioural reference: 0 ok, 1 illegal, 2 virtual fault
    function automatic int expect_of();
        int a = int'(csr_addr);
        bit below_m = (priv_mode != 2'b11);
        bit newer = 0;
        int r = 1;
        if ((a == 'h14D) || (a == 'h15D) || (a == 'h24D) || (a == 'h25D) ||
            (a >= 'h10C && a <= 'h10F) || (a >= 'h30C && a <= 'h31F && (a & 'hC) == 'hC) ||
            (a >= 'h60C && a <= 'h61F && (a & 'hC) == 'hC))
            newer = 1;
        if (a == 'h300 || a == 'h340 || (a >= 'hF11 && a <= 'hF14)) r = 0;
        else if (a == 'h140) r = en_smode ? 0 : 1;
        else if (a == 'h600) r = en_hmode ? 0 : 1;
        else if (a == 'h14D || a == 'h15D || a == 'h24D || a == 'h25D) begin
            bit mode = (a >= 'h200) ? en_hmode : en_smode;
            bit high = (a == 'h15D || a == 'h25D);
            if (!en_sstc || !time_present || (high && !xlen32) || !mode) r = 1;
            else if (dbg_access || !below_m) r = 0;
            else if (!mcnt_tm || !menv_stce) r = 1;
            else if (virt_mode && (!hcnt_tm || !henv_stce)) r = 2;
            else r = 0;
        end else if (newer) begin
            bit high = ((a & 'h10) != 0) && a >= 'h300;
            bit is_m = (a >= 'h30C && a <= 'h31F);
            bit mode = (a >= 'h600) ? en_hmode : en_smode;
            if (!en_stateen || (high && !xlen32)) r = 1;
            else if (is_m) r = 0;
            else if (!mode) r = 1;
            else if (dbg_access) r = 0;
            else if (below_m && !mstateen_top[a % 4]) r = 1;
            else r = 0;
        end else if (a >= 'h3A0 && a <= 'h3AF) begin
            int k = a - 'h3A0;
            r = (!en_pmp || (!xlen32 && k < 4 && (k % 2) == 1)) ? 1 : 0;
        end else if (a >= 'h3B0 && a <= 'h3BF) r = en_pmp ? 0 : 1;
        if (newer && impl_ver < 2) r = 1;
        if (wr_intent && a >= 'hC00) r = 1;
        if (!en_csr_insn) r = 1;
        return r;
    endfunction

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input int exp);
        n_run++;
        if (int'(verdict) !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%03h: actual %0d expected %0d", tag, csr_addr, verdict, exp);
        end
    endtask

    task automatic probe(input string tag, input logic [11:0] a, input int exp);
        csr_addr = a;
        step();
        chk(tag, exp);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    logic [11:0] pool [0:23];

    initial begin
        baseline();
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R12: baseline and encoding
        probe("R12 plain mstatus", 12'h300, 0);
        en_smode = 0; probe("R12 sscratch no S", 12'h140, 1); baseline();
        probe("R12 hstatus", 12'h600, 0);

        // R1
        wr_intent = 1; probe("R1 write read-only", 12'hF11, 1);
        virt_mode = 1; priv_mode = 2'b01; probe("R1 write ro under virt", 12'hC01, 1);
        baseline(); probe("R1 read read-only", 12'hF12, 0);

        // R2
        en_csr_insn = 0; probe("R2 insn disabled", 12'h300, 1); baseline();

        // R3
        impl_ver = 2'd1; probe("R3 old version tcmp", 12'h14D, 1);
        probe("R3 old version plain", 12'h300, 0); baseline();

        // R4
        probe("R4 unknown", 12'h7FF, 1);
        probe("R4 unknown near tcmp", 12'h14E, 1);

        // R5
        en_sstc = 0; probe("R5 sstc off", 12'h14D, 1); baseline();
        time_present = 0; probe("R5 no time source", 12'h14D, 1); baseline();
        en_hmode = 0; probe("R5 vs needs H", 12'h24D, 1);
        probe("R5 s ignores H", 12'h14D, 0); baseline();

        // R6
        priv_mode = 2'b01; mcnt_tm = 0; dbg_access = 1; probe("R6 debugger bypass", 12'h14D, 0);
        en_smode = 0; probe("R6 mode before bypass", 12'h14D, 1); baseline();
        mcnt_tm = 0; probe("R6 M always", 12'h14D, 0); baseline();

        // R7
        priv_mode = 2'b01; mcnt_tm = 0; probe("R7 mcnt clear", 12'h14D, 1);
        mcnt_tm = 1; menv_stce = 0; probe("R7 stce clear", 12'h14D, 1);
        menv_stce = 1; probe("R7 both set", 12'h14D, 0); baseline();

        // R8
        priv_mode = 2'b01; virt_mode = 1; hcnt_tm = 0; probe("R8 hcnt clear", 12'h14D, 2);
        hcnt_tm = 1; henv_stce = 0; probe("R8 henv clear", 12'h24D, 2);
        mcnt_tm = 0; probe("R8 illegal wins", 12'h14D, 1); baseline();

        // R9
        probe("R9 high rv64", 12'h15D, 1);
        xlen32 = 1; probe("R9 high rv32", 12'h25D, 0);
        probe("R9 stateen high rv32", 12'h61F, 0); baseline();
        probe("R9 stateen high rv64", 12'h31C, 1);

        // R10
        priv_mode = 2'b01; mstateen_top = 4'b1011;
        probe("R10 index clear", 12'h10E, 1);
        probe("R10 index set", 12'h10D, 0);
        probe("R10 h index clear", 12'h60E, 1);
        dbg_access = 1; probe("R10 debugger", 12'h10E, 0); dbg_access = 0;
        priv_mode = 2'b11; probe("R10 machine level", 12'h10E, 0);
        en_smode = 0; probe("R10 S needed", 12'h10C, 1);
        probe("R10 machine set", 12'h30E, 0); baseline();
        en_stateen = 0; probe("R10 feature off", 12'h30C, 1); baseline();

        // R11
        probe("R11 odd cfg rv64", 12'h3A1, 1);
        probe("R11 odd cfg3 rv64", 12'h3A3, 1);
        probe("R11 even cfg", 12'h3A2, 0);
        probe("R11 odd high index", 12'h3A5, 0);
        xlen32 = 1; probe("R11 odd cfg rv32", 12'h3A1, 0); baseline();
        en_pmp = 0; probe("R11 pmp off", 12'h3B0, 1); baseline();

        // Random comparison against the reference on every clock (R12 mix)
        pool = '{12'h300, 12'h340, 12'hF11, 12'hF14, 12'h140, 12'h600, 12'h14D, 12'h15D,
                 12'h24D, 12'h25D, 12'h10C, 12'h10F, 12'h60D, 12'h61E, 12'h30C, 12'h31D,
                 12'h3A0, 12'h3A1, 12'h3A3, 12'h3A7, 12'h3B5, 12'h7C0, 12'hC00, 12'h14C};
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            csr_addr = pool[$urandom_range(0, 23)];
            wr_intent = rv[0]; virt_mode = rv[1]; dbg_access = (rv[4:2] == 0);
            priv_mode = (rv[6:5] == 2'b10) ? 2'b01 : rv[6:5];
            xlen32 = rv[7]; impl_ver = (rv[9:8] == 0) ? 2'd1 : 2'd2;
            en_csr_insn = (rv[13:10] != 0); en_smode = (rv[15:14] != 0);
            en_hmode = (rv[17:16] != 0); en_sstc = (rv[19:18] != 0);
            time_present = (rv[21:20] != 0); en_stateen = (rv[23:22] != 0);
            en_pmp = (rv[25:24] != 0); mcnt_tm = (rv[27:26] != 0);
            menv_stce = (rv[29:28] != 0); hcnt_tm = rv[30]; henv_stce = rv[31];
            mstateen_top = 4'($urandom);
            step();
            chk("R12 random vs model", expect_of());
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule